// File: doc/BRIEF.md
# Active-Low Interrupt Status Controller

This block collects eight interrupt sources into one request line for a processor. A write-only enable byte selects which sources may raise a request. A read-only status byte reports pending sources with inverted polarity: a bit reads 1 while idle and drops to 0 once its source has fired. A pending bit is not cleared by writing to the status byte. Software clears it by writing 0 to the matching enable bit and then writing 1 again to re-arm the source.

Seven of the sources are single-cycle event pulses, and each one is held in its own latch. Source 3 has no latch. It is a level that tracks whether the serial transmitter has nothing left to send. Its status bit reads 0 while the transmitter is empty and 1 otherwise, and its enable bit has no effect on it. The request output is active-low. It is asserted whenever an enabled source shows a 0 in the status byte.

Software must program the enable byte before it opens processor interrupts, because after reset the enable contents are treated as undefined. In this implementation the enable register resets to all zeros. The asynchronous reset is released through a two-stage synchronizer, so the block leaves reset two clock edges after `rst_n` rises.

Top module: `irq_status_ctrl`

## Requirements
- R1: While in reset, and after reset until the first enable write, every latched status bit (all bits except bit 3) reads 1, the enable byte is 0 and `irq_n_o` is 1.
- R2: When `en_wr_i` is 1, the enable byte takes the value `en_wdata_i` at that clock edge; bit i of the enable byte gates source i.
- R3: An `evt_i[i]` pulse (i ≠ 3) drives `status_o[i]` to 0 from the next clock edge, provided enable bit i was already 1 and stays 1 in that cycle. The bit then stays 0 for as long as enable bit i remains 1.
- R4: An `evt_i[i]` pulse while enable bit i is 0 has no effect: `status_o[i]` stays 1.
- R5: Writing 0 to enable bit i (i ≠ 3) returns `status_o[i]` to 1 at that edge, and re-enabling the source does not bring the old event back.
- R6: If an event lands in the same cycle as a write that clears its enable bit, the clear wins. If an event lands in the same cycle as a write that sets its enable bit from 0, the event is not recorded.
- R7: `status_o[3]` equals the inverse of `ser_out_empty_i` at all times, whatever enable bit 3 holds, and `evt_i[3]` is ignored.
- R8: `irq_n_o` is 0 exactly when some bit i has enable bit i = 1 and `status_o[i]` = 0; otherwise it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 8 | Event pulses, one per source (bit 3 unused) |
| ser_out_empty_i | input | 1 | Level: serial transmitter empty |
| en_wr_i | input | 1 | Enable-byte write strobe |
| en_wdata_i | input | 8 | Enable-byte write data |
| status_o | output | 8 | Status byte, 0 means pending |
| irq_n_o | output | 1 | Active-low interrupt request |

## Verification
The hardest situations to reach are the same-cycle collisions: an event arriving together with a write that clears its enable bit, and an event arriving together with a write that sets it. Random traffic almost never lines these up on the same bit, so directed steps aim an event pulse at the exact cycle of each kind of enable write. The random phase then mixes dense event pulses with frequent enable writes and a toggling serial-empty level, so that these collisions and the bit-3 contribution to the request line also occur in many mixed states.

// File: rtl/irq_status_pkg.sv
package irq_status_pkg;
  localparam int unsigned NUM_SRC = 8;
  localparam int unsigned LEVEL_IDX = 3;
  typedef logic [NUM_SRC-1:0] src_vec_t;
  localparam src_vec_t LEVEL_MASK = src_vec_t'(1) << LEVEL_IDX;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/irq_en_reg.sv
module irq_en_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] en_q_o,
  output logic [W-1:0] en_eff_o
);
  logic [W-1:0] en_q;
  logic [W-1:0] en_d;

  always_comb begin
    en_d = en_q;
    if (wr_i) en_d = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= en_d;
  end

  assign en_q_o   = en_q;
  assign en_eff_o = en_d;
endmodule

// File: rtl/irq_latch_bank.sv
module irq_latch_bank #(
  parameter int unsigned W = 8,
  parameter int unsigned LVL = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt_i,
  input  logic [W-1:0] en_q_i,
  input  logic [W-1:0] en_eff_i,
  input  logic         level_n_i,
  output logic [W-1:0] status_o
);
  for (genvar i = 0; i < W; i++) begin : g_src
    if (i == LVL) begin : g_level
      assign status_o[i] = level_n_i;
    end else begin : g_latch
      logic pend_q;
      logic pend_d;
      logic set_ok;

      always_comb begin
        set_ok = evt_i[i] & en_q_i[i];
        pend_d = en_eff_i[i] & (pend_q | set_ok);
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= pend_d;
      end

      assign status_o[i] = ~pend_q;
    end
  end
endmodule

// File: rtl/irq_req_gen.sv
module irq_req_gen #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] status_i,
  input  logic [W-1:0] en_q_i,
  output logic         irq_n_o
);
  logic [W-1:0] active;

  always_comb begin
    active  = ~status_i & en_q_i;
    irq_n_o = ~(|active);
  end
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import irq_status_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] evt_i,
  input  logic       ser_out_empty_i,
  input  logic       en_wr_i,
  input  logic [7:0] en_wdata_i,
  output logic [7:0] status_o,
  output logic       irq_n_o
);
  logic     rst_n_int;
  src_vec_t en_q;
  src_vec_t en_eff;
  src_vec_t status;

  irq_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  irq_en_reg #(.W(NUM_SRC)) u_en (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .wr_i     (en_wr_i),
    .wdata_i  (en_wdata_i),
    .en_q_o   (en_q),
    .en_eff_o (en_eff)
  );

  irq_latch_bank #(.W(NUM_SRC), .LVL(LEVEL_IDX)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .evt_i     (evt_i),
    .en_q_i    (en_q),
    .en_eff_i  (en_eff),
    .level_n_i (~ser_out_empty_i),
    .status_o  (status)
  );

  irq_req_gen #(.W(NUM_SRC)) u_req (
    .status_i (status),
    .en_q_i   (en_q),
    .irq_n_o  (irq_n_o)
  );

  assign status_o = status;
endmodule

// File: rtl/irq_status_ctrl_chk.sv
module irq_status_ctrl_chk
  import irq_status_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] evt_i,
  input logic       ser_out_empty_i,
  input logic       en_wr_i,
  input logic [7:0] en_wdata_i,
  input logic [7:0] status_o,
  input logic       irq_n_o
);
  localparam src_vec_t LM = ~LEVEL_MASK;

  AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ((~status_o & $past(status_o) & LM & ~$past(evt_i)) == '0)); // R3

  AST_PENDING_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en_wr_i) |-> ((~$past(status_o) & status_o & LM) == '0)); // R3

  AST_CLEAR_BY_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
    en_wr_i |=> ((~status_o & ~$past(en_wdata_i) & LM) == '0)); // R5

  AST_LEVEL_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[LEVEL_IDX] == !ser_out_empty_i); // R7

  AST_IRQ_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n_o |-> (status_o != 8'hFF)); // R8
endmodule

bind irq_status_ctrl irq_status_ctrl_chk u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .evt_i           (evt_i),
  .ser_out_empty_i (ser_out_empty_i),
  .en_wr_i         (en_wr_i),
  .en_wdata_i      (en_wdata_i),
  .status_o        (status_o),
  .irq_n_o         (irq_n_o)
);

// File: tb/tb_irq_status_ctrl.sv
module tb_irq_status_ctrl;
  logic       clk;
  logic       rst_n;
  logic [7:0] evt_i;
  logic       ser_out_empty_i;
  logic       en_wr_i;
  logic [7:0] en_wdata_i;
  logic [7:0] status_o;
  logic       irq_n_o;

  int checks = 0;
  int errors = 0;
  logic [7:0] m_en;
  logic [7:0] m_pend;
  bit done = 0;

  localparam logic [7:0] LVL = 8'h08;

  irq_status_ctrl dut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .ser_out_empty_i(ser_out_empty_i),
    .en_wr_i(en_wr_i), .en_wdata_i(en_wdata_i), .status_o(status_o), .irq_n_o(irq_n_o)
  );

  initial clk = 0;
  always #10 clk = ~clk;

  function automatic logic [7:0] next_pend(logic [7:0] p, logic [7:0] en, logic wr,
                                           logic [7:0] wd, logic [7:0] ev);
    logic [7:0] eff;
    eff = wr ? wd : en;
    return eff & (p | (ev & en)) & ~LVL;
  endfunction

  function automatic logic [7:0] exp_status(logic [7:0] p, logic ser);
    logic [7:0] s;
    s = ~p;
    s[3] = ~ser;
    return s;
  endfunction

  function automatic logic exp_irq(logic [7:0] s, logic [7:0] en);
    return ~(|(~s & en));
  endfunction

  task automatic check(string tag);
    logic [7:0] es;
    logic ei;
    es = exp_status(m_pend, ser_out_empty_i);
    ei = exp_irq(es, m_en);
    checks++;
    if (status_o !== es || irq_n_o !== ei) begin
      errors++;
      $display("FAIL %s: status=%h irq_n=%b expected status=%h irq_n=%b",
               tag, status_o, irq_n_o, es, ei);
    end
  endtask

  // Apply one cycle of stimulus at the falling edge, advance the model, check after the next rising edge.
  task automatic step(logic [7:0] ev, logic wr, logic [7:0] wd, logic ser, string tag);
    evt_i = ev; en_wr_i = wr; en_wdata_i = wd; ser_out_empty_i = ser;
    m_pend = next_pend(m_pend, m_en, wr, wd, ev);
    if (wr) m_en = wd;
    @(posedge clk);
    @(negedge clk);
    evt_i = '0; en_wr_i = 0;
    check(tag);
  endtask

  initial begin
    int unsigned seed;
    seed = 32'h1234_5678;
    void'($urandom(seed));
    rst_n = 0; evt_i = '0; en_wr_i = 0; en_wdata_i = '0; ser_out_empty_i = 0;
    m_en = '0; m_pend = '0;
    repeat (3) @(negedge clk);
    check("R1");
    rst_n = 1;
    repeat (3) @(negedge clk);
    check("R1");
    // R4: events with everything disabled
    step(8'hFF, 0, 8'h00, 0, "R4");
    // R2/R3: enable then fire
    step(8'h00, 1, 8'hF7, 0, "R2");
    step(8'h05, 0, 8'h00, 0, "R3");
    step(8'h00, 0, 8'h00, 0, "R3");
    step(8'h00, 0, 8'h00, 0, "R8");
    // R5: clear bit 0 only, then re-enable
    step(8'h00, 1, 8'hF6, 0, "R5");
    step(8'h00, 1, 8'hF7, 0, "R5");
    // R6: clear-with-event on bit 2, set-with-event on bit 0
    step(8'h04, 1, 8'hF3, 0, "R6");
    step(8'h00, 1, 8'h00, 0, "R6");
    step(8'h01, 1, 8'h01, 0, "R6");
    step(8'h00, 0, 8'h00, 0, "R6");
    // R7: level bit with enable off and on
    step(8'h08, 0, 8'h00, 1, "R7");
    step(8'h00, 1, 8'h08, 1, "R8");
    step(8'h00, 0, 8'h00, 0, "R7");
    step(8'h00, 1, 8'h00, 1, "R7");
    // random phase
    for (int n = 0; n < 3000; n++) begin
      logic [7:0] ev;
      logic wr;
      ev = 8'($urandom) & 8'($urandom);
      wr = ($urandom % 5) == 0;
      step(ev, wr, 8'($urandom), 1'($urandom), "R3");
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule